// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block is a purely combinational 64-bit adder/subtractor whose carry chain can be broken at byte boundaries under a runtime select. A single datapath therefore works as eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Each lane computes independently, with no carry or borrow leaking into its neighbour.

Each lane can treat its operands as signed or unsigned. Each lane reports overflow for its own interpretation. Each lane either wraps modulo 2^n or clamps to the nearest representable bound.

A media or packed-arithmetic execution stage drives the operands and the four control selects. It takes the result and the per-lane overflow vector in the same cycle.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sz` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, and 2'b10 or 2'b11 give 32-bit lanes. Lane k occupies bits [n*k+n-1 : n*k], and no carry or borrow passes between lanes.
- R2: With `sub_en`=0, each lane's result is (a + b) mod 2^n when that lane does not saturate.
- R3: With `sub_en`=1, each lane's result is (a + ~b + 1) mod 2^n, that is a − b, when that lane does not saturate.
- R4: With `signed_en`=0, a lane overflows on add when the true sum exceeds 2^n−1, and on subtract when a < b.
- R5: With `signed_en`=1 and add, a lane overflows only when both operands share a sign and the result sign differs from it. Operands of opposite sign never overflow.
- R6: With `signed_en`=1 and subtract, a lane overflows when a is negative, b is non-negative and the result is non-negative. It also overflows when a is non-negative, b is negative and the result is negative.
- R7: `ovf_o` has one bit per byte. A lane's overflow is reported in the bit of its lowest byte (bit k*n/8). All other bits are 0.
- R8: With `sat_en`=1 and unsigned mode, an overflowing lane returns all ones on add and zero on subtract.
- R9: With `sat_en`=1 and signed mode, an overflowing lane returns 0x7F…F when operand a is non-negative and 0x80…0 when it is negative.
- R10: With `sat_en`=0, an overflowing lane returns the wrapped result, and its overflow bit is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand, packed lanes |
| op_b | input | 64 | Second operand, packed lanes |
| lane_sz | input | 2 | Lane width select |
| sub_en | input | 1 | 1 = subtract b from a, 0 = add |
| signed_en | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| sat_en | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| sum_o | output | 64 | Packed lane results |
| ovf_o | output | 8 | Per-lane overflow, at each lane's lowest byte |

## Verification
The bench builds the block with its default 64-bit width, so all three lane widths are available, as is the fourth, aliased select code. With all three widths, carries driven across every byte edge show which edges are cut and which are kept, for each lane size. The flag-placement rule can be seen at 8-, 16- and 32-bit granularity. Signed and unsigned bounds are driven at each width, so both clamping directions occur in the narrowest and the widest lanes.

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [1:0]          lane_sz,
  input  logic                sub_en,
  input  logic                signed_en,
  input  logic                sat_en,
  output logic [DATA_W-1:0]   sum_o,
  output logic [DATA_W/8-1:0] ovf_o
);
  localparam int NB = DATA_W / 8;
  localparam int IW = $clog2(NB);

  // byte index mask inside a lane: 0 for bytes, 1 for halfwords, 3 for words
  logic [IW-1:0] lmask;
  assign lmask = (lane_sz == 2'b00) ? IW'(0) :
                 (lane_sz == 2'b01) ? IW'(1) : IW'(3);

  logic [NB:0]   cy;
  logic [NB-1:0] cin_v;
  logic [7:0]    raw [NB];
  logic [NB-1:0] top_ov;
  logic [NB-1:0] top_neg;

  always_comb begin
    cy[0] = 1'b0;
    for (int i = 0; i < NB; i++) begin
      cin_v[i] = ((IW'(i) & lmask) == '0) ? sub_en : cy[i];
      {cy[i+1], raw[i]} = {1'b0, op_a[8*i +: 8]}
                        + {1'b0, op_b[8*i +: 8] ^ {8{sub_en}}}
                        + {8'b0, cin_v[i]};
    end
  end

  // overflow and clamp direction, as seen if byte j were a lane's top byte
  always_comb begin
    for (int j = 0; j < NB; j++) begin
      if (signed_en) begin
        top_ov[j]  = sub_en ?
          ((op_a[8*j+7] != op_b[8*j+7]) && (raw[j][7] != op_a[8*j+7])) :
          ((op_a[8*j+7] == op_b[8*j+7]) && (raw[j][7] != op_a[8*j+7]));
        top_neg[j] = op_a[8*j+7];
      end else begin
        top_ov[j]  = sub_en ? ~cy[j+1] : cy[j+1];
        top_neg[j] = sub_en;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      logic [IW-1:0] t;
      t = IW'(i) | lmask;
      ovf_o[i] = ((IW'(i) & lmask) == '0) && top_ov[t];
      if (sat_en && top_ov[t]) begin
        if (signed_en && (t == IW'(i)))
          sum_o[8*i +: 8] = top_neg[t] ? 8'h80 : 8'h7F;
        else
          sum_o[8*i +: 8] = top_neg[t] ? 8'h00 : 8'hFF;
      end else begin
        sum_o[8*i +: 8] = raw[i];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NB; j++) begin
      if ((IW'(j) & lmask) != '0)
        assert_flag_lowbyte_R7: assert (!ovf_o[j]);
      if (lane_sz == 2'b00 && signed_en && !sub_en &&
          op_a[8*j+7] != op_b[8*j+7])
        assert_no_opp_ovf_R5: assert (!ovf_o[j]);
      if (lane_sz == 2'b00 && !signed_en && sat_en && !sub_en)
        assert_usat_add_R8: assert (sum_o[8*j +: 8] >= op_a[8*j +: 8]);
      if (lane_sz == 2'b00 && !signed_en && sat_en && sub_en)
        assert_usat_sub_R8: assert (sum_o[8*j +: 8] <= op_a[8*j +: 8]);
      if (lane_sz == 2'b00 && signed_en && sat_en && ovf_o[j])
        assert_ssat_bound_R9: assert (sum_o[8*j +: 8] == 8'h7F ||
                                      sum_o[8*j +: 8] == 8'h80);
    end
  end
endmodule

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sz = 2'b00;
  logic        sub_en = 1'b0, signed_en = 1'b0, sat_en = 1'b0;
  logic [63:0] sum_o;
  logic [7:0]  ovf_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  simd_sat_adder #(.DATA_W(64)) dut_i (
    .op_a(op_a), .op_b(op_b), .lane_sz(lane_sz), .sub_en(sub_en),
    .signed_en(signed_en), .sat_en(sat_en), .sum_o(sum_o), .ovf_o(ovf_o)
  );

  function automatic void ref_op(input logic [63:0] a, input logic [63:0] b,
                                 input logic [1:0] sz, input logic sb,
                                 input logic sg, input logic st,
                                 output logic [63:0] r, output logic [7:0] f);
    int bpl;
    int n;
    bpl = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    n = 8 * bpl;
    r = '0;
    f = '0;
    for (int k = 0; k < 8 / bpl; k++) begin
      logic [32:0] ua, ub, full;
      logic [31:0] mask, res;
      logic as, bs, rs, ov;
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
      ua = {1'b0, 32'(a >> (k * n)) & mask};
      ub = {1'b0, 32'(b >> (k * n)) & mask};
      full = sb ? (ua - ub) : (ua + ub);
      res = full[31:0] & mask;
      as = ua[n-1];
      bs = ub[n-1];
      rs = res[n-1];
      if (sg) ov = sb ? (as != bs && rs != as) : (as == bs && rs != as);
      else    ov = sb ? (ua < ub) : full[n];
      if (ov && st) begin
        if (sg) res = as ? (32'd1 << (n - 1)) : (mask >> 1);
        else    res = sb ? 32'd0 : mask;
      end
      r = r | (64'(res) << (k * n));
      f[k * bpl] = ov;
    end
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input logic [1:0] sz, input logic sb, input logic sg,
                     input logic st, input string req);
    logic [63:0] er;
    logic [7:0]  ef;
    @(posedge clk);
    op_a = a; op_b = b; lane_sz = sz; sub_en = sb; signed_en = sg; sat_en = st;
    ref_op(a, b, sz, sb, sg, st, er, ef);
    @(negedge clk);
    n_checks++;
    if (sum_o !== er) begin
      n_fail++;
      $display("FAIL %s result: actual %h expected %h", req, sum_o, er);
    end
    n_checks++;
    if (ovf_o !== ef) begin
      n_fail++;
      $display("FAIL %s flags: actual %b expected %b", req, ovf_o, ef);
    end
  endtask

  task automatic t_idle();
    run(64'h0, 64'h0, 2'b00, 1'b0, 1'b0, 1'b0, "R2 zero");
  endtask

  task automatic t_lane_cut(); // R1
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 0, "R1 8b");
    run(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b01, 0, 0, 0, "R1 16b");
    run(64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 0, 0, 0, "R1 32b");
    run(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 2'b11, 1, 0, 0, "R1 code3");
    run(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'b01, 1, 0, 0, "R1 16b sub");
  endtask

  task automatic t_wrap(); // R2 R3 R10
    run(64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, 2'b10, 0, 0, 0, "R2 32b");
    run(64'h7F80_FF00_1020_3040, 64'h0101_0101_F0E0_D0C0, 2'b00, 0, 1, 0, "R10 signed wrap");
    run(64'h0000_0005_0010_0001, 64'h0000_0006_0020_0002, 2'b01, 1, 0, 0, "R3 borrow wrap");
  endtask

  task automatic t_unsigned(); // R4 R8
    run(64'hF0F0_F0F0_0F0F_0F0F, 64'h2020_2020_0101_0101, 2'b00, 0, 0, 1, "R8 add sat");
    run(64'h1000_0001_8000_0000, 64'h2000_0002_7FFF_FFFF, 2'b10, 1, 0, 1, "R8 sub sat");
    run(64'hFFFF_0000_8000_7FFF, 64'h0001_0000_8000_8000, 2'b01, 0, 0, 0, "R4 carry");
  endtask

  task automatic t_signed(); // R5 R6 R9
    run(64'h7F80_7F80_0180_7F01, 64'h0180_8001_7F7F_7F01, 2'b00, 0, 1, 1, "R9 R5 8b");
    run(64'h8000_7FFF_8000_0001, 64'h0001_FFFF_7FFF_0002, 2'b01, 1, 1, 1, "R9 R6 16b");
    run(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'b10, 1, 1, 1, "R9 R6 32b");
    run(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 2'b10, 0, 1, 1, "R9 R5 32b");
    run(64'h80FF_7F00_40C0_FF01, 64'h7F01_8000_C040_01FF, 2'b00, 0, 1, 0, "R5 opposite");
    run(64'h7F80_0080_FF7F_1080, 64'hFF7F_7F01_0180_20FF, 2'b00, 1, 1, 0, "R6 rules");
  endtask

  task automatic t_flags(); // R7
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 0, 0, 0, "R7 8b");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 0, 0, 0, "R7 16b");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 0, 0, 0, "R7 32b");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_lane_cut();
    t_wrap();
    t_unsigned();
    t_signed();
    t_flags();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule